// File: doc/BRIEF.md
# NAND Bus Access Bridge

This block connects a 32-bit memory-mapped processor port to an 8-bit raw NAND flash bus. A processor access falls either in a small register space or in the flash window. In the window, address bits pick the chip enable, the secondary die select and the bus phase: a command latch cycle, an address latch cycle or a plain data cycle. One processor access becomes one, two or four flash byte strobes, lowest byte first. The processor is held off until the last strobe has finished. For reads, the word is assembled from the strobed bytes before it is returned.

The register space holds a control word and a status word. The control word enables each primary chip select for flash use and sets the strobe low width in clock cycles. The status word reports the ready/busy line, which all attached flash devices share as a wired-AND.

Top module: `nand_bridge`

## Requirements
- R1: After synchronous reset, every chip enable and both strobes are high, CLE, ALE, `nand_dq_oe` and `cpu_ready` are low. The control word reads mode bits 0 and strobe width field 2.
- R2: A window access with address bit 3 set and bit 4 clear drives ALE high and CLE low on every byte strobe of that access.
- R3: A window access with address bit 4 set drives CLE high on every byte strobe. ALE stays low even when bit 3 is also set, and CLE and ALE are never both high.
- R4: `cpu_size` 2'b00 gives one byte strobe, 2'b01 gives two and 2'b10 gives four. Bytes go least significant first, starting at `cpu_wdata[7:0]`. Address bits [1:0] have no effect.
- R5: Address bits [9:8] select primary chip select N. `nand_ce_n[N]` goes low for the access only when control bit N is set. If control bit N is clear, the access completes in one cycle with no strobe, and read data is 0.
- R6: Address bit 12 set during a window access drives `nand_ce2_n` low for every strobe of that access. With bit 12 clear, `nand_ce2_n` stays high.
- R7: Address bit 14 selects the register space. Address bit 2 = 0 is the control word; address bit 2 = 1 is the status word. Status bit 0 equals `nand_rdy` as seen through a two-stage synchronizer. Writes to the status word are ignored.
- R8: Control bits [19:16] set the strobe low width in clock cycles. A value of 0 acts as 1, but reads back as 0.
- R9: `cpu_ready` is a one-cycle pulse. For a window access with n strobes and width w, it arrives n*(w+2) cycles after the accept edge. For register and disabled-select accesses, it arrives on the accept edge itself.
- R10: On a read, byte k of the access appears at `cpu_rdata[8k+7:8k]`. Lanes that were not strobed read 0.
- R11: Writes drive the data byte on `nand_dq_out` with `nand_dq_oe` high, using `nand_we_n` pulses. Reads pulse `nand_re_n` with `nand_dq_oe` low.
- R12: At most one primary chip enable is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 half, 10/11 word |
| cpu_addr | input | AW (16) | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Completion pulse |
| nand_ce_n | output | NCS (4) | Primary chip enables, active low |
| nand_ce2_n | output | 1 | Secondary die select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Flash data output enable |
| nand_dq_in | input | 8 | Flash data in |
| nand_rdy | input | 1 | Wired-AND ready/busy line |

## Verification
The bench uses the default parameters: four primary selects, the secondary select enabled on bit 12, and a reset strobe width of 2. With these defaults, every select index, both the CLE/ALE overlap and the secondary select case, and all three access sizes are reachable. By rewriting the control word, the bench sweeps strobe widths 0 through 5, so both the zero-as-one rule and multi-cycle pulses are checked against exact latencies. It also enables only some selects, so that ignored accesses can be seen at the ports.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } access_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs #(
  parameter int NCS    = 4,
  parameter int PWW    = 4,
  parameter int PW_LSB = 16,
  parameter int DEF_PW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [31:0]    wdata,
  input  logic           rd_status,
  input  logic           rdy_in,
  output logic [NCS-1:0] mode_en,
  output logic [PWW-1:0] pw_eff,
  output logic [31:0]    rd_data
);
  logic [PWW-1:0] pw_q;
  logic           rdy_s1, rdy_s2;
  logic           unused_wdata;

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_en <= '0;
      pw_q    <= PWW'(DEF_PW);
      rdy_s1  <= 1'b0;
      rdy_s2  <= 1'b0;
    end else begin
      rdy_s1 <= rdy_in;
      rdy_s2 <= rdy_s1;
      if (wr_en) begin
        mode_en <= wdata[NCS-1:0];
        pw_q    <= wdata[PW_LSB +: PWW];
      end
    end
  end

  assign pw_eff = (pw_q == '0) ? PWW'(1) : pw_q;

  always_comb begin
    rd_data = '0;
    if (rd_status) begin
      rd_data[0] = rdy_s2;
    end else begin
      rd_data[NCS-1:0]         = mode_en;
      rd_data[PW_LSB +: PWW]   = pw_q;
    end
  end
endmodule

// File: rtl/nand_bridge_decode.sv
module nand_bridge_decode #(
  parameter int AW      = 16,
  parameter int NCS     = 4,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3,
  parameter int CS_LSB  = 8,
  parameter int SEC_BIT = 12,
  parameter bit SEC_EN  = 1'b1
) (
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     size,
  input  logic [NCS-1:0] mode_en,
  output logic [NCS-1:0] ce_sel,
  output logic           ce2_sel,
  output logic           cle_sel,
  output logic           ale_sel,
  output logic [1:0]     last_idx,
  output logic           target_on
);
  import nand_bridge_pkg::*;

  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [CSW-1:0] cs_idx;
  logic           unused_addr;

  assign unused_addr = ^addr;
  assign cs_idx      = addr[CS_LSB +: CSW];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign ce_sel[i] = (cs_idx == CSW'(i)) && mode_en[i];
  end

  if (SEC_EN) begin : g_sec
    assign ce2_sel = addr[SEC_BIT];
  end else begin : g_nosec
    assign ce2_sel = 1'b0;
  end

  assign target_on = |ce_sel;
  assign cle_sel   = addr[CLE_BIT];
  assign ale_sel   = addr[ALE_BIT] & ~addr[CLE_BIT];

  always_comb begin
    case (size)
      SZ_BYTE: last_idx = 2'd0;
      SZ_HALF: last_idx = 2'd1;
      default: last_idx = 2'd3;
    endcase
  end
endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq #(
  parameter int NCS = 4,
  parameter int PWW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic           we,
  input  logic           is_reg,
  input  logic [31:0]    wdata,
  input  logic [NCS-1:0] ce_sel,
  input  logic           ce2_sel,
  input  logic           cle_sel,
  input  logic           ale_sel,
  input  logic [1:0]     last_idx,
  input  logic           target_on,
  input  logic [PWW-1:0] pw_eff,
  input  logic [31:0]    reg_rdata,
  input  logic [7:0]     dq_in,
  output logic           reg_wr,
  output logic           cpu_ready,
  output logic [31:0]    cpu_rdata,
  output logic [NCS-1:0] ce_n,
  output logic           ce2_n,
  output logic           cle,
  output logic           ale,
  output logic           we_n,
  output logic           re_n,
  output logic [7:0]     dq_out,
  output logic           dq_oe
);
  import nand_bridge_pkg::*;

  seq_state_e     state;
  logic [1:0]     byte_idx, last_q;
  logic           wr_q;
  logic [23:0]    shift_q;
  logic [31:0]    rbuf;
  logic [PWW-1:0] pw_cnt;
  logic           accept;

  assign accept = req && !cpu_ready && (state == ST_IDLE);
  assign reg_wr = accept && is_reg && we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      byte_idx  <= '0;
      last_q    <= '0;
      wr_q      <= 1'b0;
      shift_q   <= '0;
      rbuf      <= '0;
      pw_cnt    <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      ce_n      <= '1;
      ce2_n     <= 1'b1;
      cle       <= 1'b0;
      ale       <= 1'b0;
      we_n      <= 1'b1;
      re_n      <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (is_reg) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= we ? 32'd0 : reg_rdata;
            end else if (!target_on) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= '0;
            end else begin
              ce_n     <= ~ce_sel;
              ce2_n    <= ~ce2_sel;
              cle      <= cle_sel;
              ale      <= ale_sel;
              dq_oe    <= we;
              dq_out   <= we ? wdata[7:0] : 8'd0;
              shift_q  <= we ? wdata[31:8] : 24'd0;
              wr_q     <= we;
              last_q   <= last_idx;
              byte_idx <= '0;
              rbuf     <= '0;
              state    <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (wr_q) we_n <= 1'b0;
          else      re_n <= 1'b0;
          pw_cnt <= pw_eff - PWW'(1);
          state  <= ST_STROBE;
        end
        ST_STROBE: begin
          if (pw_cnt == '0) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (!wr_q) rbuf[{byte_idx, 3'b000} +: 8] <= dq_in;
            state <= ST_HOLD;
          end else begin
            pw_cnt <= pw_cnt - PWW'(1);
          end
        end
        default: begin
          if (byte_idx == last_q) begin
            ce_n      <= '1;
            ce2_n     <= 1'b1;
            cle       <= 1'b0;
            ale       <= 1'b0;
            dq_oe     <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= rbuf;
            state     <= ST_IDLE;
          end else begin
            byte_idx <= byte_idx + 2'd1;
            dq_out   <= shift_q[7:0];
            shift_q  <= {8'd0, shift_q[23:8]};
            state    <= ST_SETUP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge #(
  parameter int AW      = 16,
  parameter int NCS     = 4,
  parameter int PWW     = 4,
  parameter int DEF_PW  = 2,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3,
  parameter int CS_LSB  = 8,
  parameter int SEC_BIT = 12,
  parameter bit SEC_EN  = 1'b1,
  parameter int REG_BIT = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [1:0]     cpu_size,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [31:0]    cpu_wdata,
  output logic [31:0]    cpu_rdata,
  output logic           cpu_ready,
  output logic [NCS-1:0] nand_ce_n,
  output logic           nand_ce2_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [7:0]     nand_dq_out,
  output logic           nand_dq_oe,
  input  logic [7:0]     nand_dq_in,
  input  logic           nand_rdy
);
  localparam int PW_LSB = 16;

  logic [NCS-1:0] mode_en, ce_sel;
  logic [PWW-1:0] pw_eff;
  logic [31:0]    reg_rdata;
  logic           ce2_sel, cle_sel, ale_sel, target_on, seq_reg_wr;
  logic [1:0]     last_idx;
  logic           is_reg, rd_status;

  assign is_reg    = cpu_addr[REG_BIT];
  assign rd_status = cpu_addr[2];

  nand_bridge_regs #(
    .NCS(NCS), .PWW(PWW), .PW_LSB(PW_LSB), .DEF_PW(DEF_PW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (seq_reg_wr && !rd_status),
    .wdata    (cpu_wdata),
    .rd_status(rd_status),
    .rdy_in   (nand_rdy),
    .mode_en  (mode_en),
    .pw_eff   (pw_eff),
    .rd_data  (reg_rdata)
  );

  nand_bridge_decode #(
    .AW(AW), .NCS(NCS), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT),
    .CS_LSB(CS_LSB), .SEC_BIT(SEC_BIT), .SEC_EN(SEC_EN)
  ) u_dec (
    .addr     (cpu_addr),
    .size     (cpu_size),
    .mode_en  (mode_en),
    .ce_sel   (ce_sel),
    .ce2_sel  (ce2_sel),
    .cle_sel  (cle_sel),
    .ale_sel  (ale_sel),
    .last_idx (last_idx),
    .target_on(target_on)
  );

  nand_bridge_seq #(.NCS(NCS), .PWW(PWW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (cpu_req),
    .we       (cpu_we),
    .is_reg   (is_reg),
    .wdata    (cpu_wdata),
    .ce_sel   (ce_sel),
    .ce2_sel  (ce2_sel),
    .cle_sel  (cle_sel),
    .ale_sel  (ale_sel),
    .last_idx (last_idx),
    .target_on(target_on),
    .pw_eff   (pw_eff),
    .reg_rdata(reg_rdata),
    .dq_in    (nand_dq_in),
    .reg_wr   (seq_reg_wr),
    .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata),
    .ce_n     (nand_ce_n),
    .ce2_n    (nand_ce2_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_out   (nand_dq_out),
    .dq_oe    (nand_dq_oe)
  );
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           cpu_ready,
  input logic [NCS-1:0] nand_ce_n,
  input logic           nand_cle,
  input logic           nand_ale,
  input logic           nand_we_n,
  input logic           nand_re_n,
  input logic [7:0]     nand_dq_out,
  input logic           nand_dq_oe
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (&nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale
             && !nand_dq_oe && !cpu_ready));

  assert_cle_wins_R3: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  assert_latch_held_R2: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |=> ($stable(nand_cle) && $stable(nand_ale)));

  assert_single_ce_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~nand_ce_n));

  assert_strobe_has_ce_R5: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !(&nand_ce_n));

  assert_read_no_drive_R11: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> (!nand_dq_oe && nand_we_n));

  assert_write_drives_R11: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe);

  assert_data_held_R4: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |=> $stable(nand_dq_out));

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_ready_after_bus_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (nand_we_n && nand_re_n && &nand_ce_n));
endmodule

bind nand_bridge nand_bridge_chk #(.NCS(NCS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_out(nand_dq_out),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_bridge_test.sv
module nand_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'b00;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic [3:0]  nand_ce_n;
  logic        nand_ce2_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_dq_oe;
  logic        nand_rdy = 1'b1;

  int checks = 0;
  int fails = 0;
  int n_st = 0;
  int base_g = 0;
  time t_fall = 0;
  logic fall_wr = 1'b0;
  logic [7:0] rd_bytes [4];
  logic [7:0] log_dq  [64];
  logic       log_cle [64];
  logic       log_ale [64];
  logic       log_ce2 [64];
  logic       log_wr  [64];
  logic [3:0] log_ce  [64];
  int         log_w   [64];
  int         cur_pw = 2;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bridge uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .nand_ce_n(nand_ce_n),
    .nand_ce2_n(nand_ce2_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
  );

  assign nand_dq_in = rd_bytes[(n_st - base_g) & 3];

  always @(negedge nand_we_n or negedge nand_re_n) begin
    t_fall  = $time;
    fall_wr = !nand_we_n;
  end

  always @(posedge nand_we_n or posedge nand_re_n) begin
    if (!rst) begin
      log_dq [n_st % 64] = nand_dq_out;
      log_cle[n_st % 64] = nand_cle;
      log_ale[n_st % 64] = nand_ale;
      log_ce2[n_st % 64] = nand_ce2_n;
      log_ce [n_st % 64] = nand_ce_n;
      log_wr [n_st % 64] = fall_wr;
      log_w  [n_st % 64] = int'(($time - t_fall) / CLK_PERIOD);
      n_st = n_st + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic int pw_eff(input int pw);
    return (pw == 0) ? 1 : pw;
  endfunction

  task automatic do_access(input logic we, input logic [15:0] addr,
                           input logic [1:0] sz, input logic [31:0] wd,
                           output logic [31:0] rd, output int cyc,
                           output int nst);
    int base;
    base   = n_st;
    base_g = n_st;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 2000);
    rd  = cpu_rdata;
    nst = n_st - base;
    cpu_req = 1'b0;
  endtask

  task automatic set_ctrl(input logic [3:0] mode, input int pw);
    logic [31:0] rd; int cyc, nst;
    do_access(1'b1, 16'h4000, 2'b10, {12'd0, 4'(pw), 12'd0, mode}, rd, cyc, nst);
    cur_pw = pw;
    chk(cyc == 1, "R9 register write latency", cyc, 1);
  endtask

  task automatic xfer(input logic we, input int cs, input bit sec, input bit cb,
                      input bit ab, input logic [1:0] sz, input logic [1:0] lo,
                      input logic [31:0] wd);
    logic [31:0] rd, exp_rd; logic [15:0] addr; int cyc, nst, base, nb, idx;
    addr = 16'((cs << 8) | (int'(sec) << 12) | (int'(cb) << 4) | (int'(ab) << 3) | int'(lo));
    nb = nbytes(sz);
    for (int k = 0; k < 4; k++) rd_bytes[k] = 8'($urandom);
    base = n_st;
    do_access(we, addr, sz, wd, rd, cyc, nst);
    chk(nst == nb, "R4 strobe count", nst, nb);
    chk(cyc == nb * (pw_eff(cur_pw) + 2) + 1, "R9 completion latency", cyc,
        nb * (pw_eff(cur_pw) + 2) + 1);
    for (int k = 0; k < nb && k < nst; k++) begin
      idx = (base + k) % 64;
      chk(log_cle[idx] == cb, "R3 CLE per strobe", log_cle[idx], cb);
      chk(log_ale[idx] == (ab && !cb), "R2 ALE per strobe", log_ale[idx], ab && !cb);
      chk(log_ce[idx] == ~(4'b1 << cs), "R5 chip enable", log_ce[idx], ~(4'b1 << cs));
      chk(log_ce2[idx] == !sec, "R6 secondary select", log_ce2[idx], !sec);
      chk(log_w[idx] == pw_eff(cur_pw), "R8 strobe width", log_w[idx], pw_eff(cur_pw));
      chk(log_wr[idx] == we, "R11 strobe kind", log_wr[idx], we);
      if (we) chk(log_dq[idx] == wd[8*k +: 8], "R4 byte order", log_dq[idx], wd[8*k +: 8]);
    end
    if (!we) begin
      exp_rd = '0;
      for (int k = 0; k < nb; k++) exp_rd[8*k +: 8] = rd_bytes[k];
      chk(rd == exp_rd, "R10 read assembly", rd, exp_rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; int cyc, nst;
    void'($urandom(32'd2718));
    for (int k = 0; k < 4; k++) rd_bytes[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n, "R1 reset strobes/ce",
        {nand_ce_n, nand_we_n, nand_re_n}, 6'h3F);
    chk(!nand_cle && !nand_ale && !nand_dq_oe && !cpu_ready, "R1 reset latches",
        {nand_cle, nand_ale, nand_dq_oe, cpu_ready}, 0);
    do_access(1'b0, 16'h4000, 2'b10, 0, rd, cyc, nst);
    chk(rd == 32'h0002_0000, "R1 control reset value", rd, 32'h0002_0000);

    // R5: select not in flash mode is ignored
    do_access(1'b1, 16'h0000, 2'b10, 32'hDEADBEEF, rd, cyc, nst);
    chk(nst == 0 && cyc == 1, "R5 disabled select ignored", {nst[15:0], cyc[15:0]}, 32'h0000_0001);

    // R7 status
    nand_rdy = 1'b0; repeat (3) @(negedge clk);
    do_access(1'b0, 16'h4004, 2'b10, 0, rd, cyc, nst);
    chk(rd == 32'd0, "R7 status busy", rd, 0);
    nand_rdy = 1'b1; repeat (3) @(negedge clk);
    do_access(1'b0, 16'h4004, 2'b10, 0, rd, cyc, nst);
    chk(rd == 32'd1, "R7 status ready", rd, 1);
    do_access(1'b1, 16'h4004, 2'b10, 32'h0005_000F, rd, cyc, nst);
    do_access(1'b0, 16'h4000, 2'b10, 0, rd, cyc, nst);
    chk(rd == 32'h0002_0000, "R7 status write ignored", rd, 32'h0002_0000);

    // only select 2 enabled
    set_ctrl(4'b0100, 2);
    do_access(1'b1, 16'h0100, 2'b10, 32'h1234_5678, rd, cyc, nst);
    chk(nst == 0, "R5 select 1 off", nst, 0);
    xfer(1'b1, 2, 1'b0, 1'b0, 1'b0, 2'b10, 2'b00, 32'hA1B2C3D4);

    set_ctrl(4'b1111, 2);
    xfer(1'b1, 0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 32'h0000_0070); // R3 overlap
    xfer(1'b1, 1, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11, 32'h0403_0201); // R2, R4 low bits
    xfer(1'b0, 3, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 0);             // R6, R10 byte
    xfer(1'b0, 2, 1'b0, 1'b0, 1'b0, 2'b01, 2'b10, 0);             // R10 half

    // R8: zero width acts as one, reads back zero
    set_ctrl(4'b1111, 0);
    do_access(1'b0, 16'h4000, 2'b10, 0, rd, cyc, nst);
    chk(rd == 32'h0000_000F, "R8 zero width readback", rd, 32'h0000_000F);
    xfer(1'b1, 1, 1'b1, 1'b0, 1'b0, 2'b10, 2'b00, 32'h55AA_33CC);
    set_ctrl(4'b1111, 5);
    xfer(1'b0, 0, 1'b0, 1'b0, 1'b0, 2'b10, 2'b00, 0);

    for (int i = 0; i < 40; i++) begin
      if (i % 10 == 0) set_ctrl(4'b1111, 1 + (i / 10));
      xfer(1'($urandom), int'($urandom % 4), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), 2'($urandom), $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule